// File: doc/BRIEF.md
# Receive Linked-Page DMA Writer

This block takes a received frame, presented one byte at a time by a per-port receive data FIFO with start-of-frame and end-of-frame markers, and stores it in a paged packet buffer. Each page is `PAGE_BYTES` long. The first `HDR_BYTES` of a page are set aside for a header, and the remaining `PAYLOAD = PAGE_BYTES - HDR_BYTES` bytes hold frame data. Page pointers come from a small per-port free-pointer FIFO. The block pulls one pointer each time a frame starts and one more each time the current page overflows. It links the pages into a chain by writing the header of every page once that page is finished.

A header carries two things: the pointer of the following page, or all ones for the last page, and the count of valid payload bytes in that page. When the final header is written, the block pulses a completion strobe that carries the frame's first page pointer. This strobe is the hand-off point to the transmit side in store-and-forward operation.

A frame is dropped when it would need more than `MAX_PAGES` pages, or when the free-pointer FIFO is empty at the moment a page is needed. The rest of a dropped frame is drained from the input. Every page the frame took is then handed back, one per cycle, and no completion is signalled. The block also asks for pointer refills whenever its free-pointer FIFO is not full.

Top module: `rx_page_writer`

## Requirements
- R1: Payload byte j (counting from 0) of a page whose pointer is P is written to byte address P*PAGE_BYTES + HDR_BYTES + j. The byte address is the pointer concatenated with the in-page offset.
- R2: A new page pointer is taken only when a byte arrives for a page that already holds PAYLOAD bytes. In that cycle the full page's header is written with next = the new pointer and count = PAYLOAD.
- R3: The last page of a stored frame gets a header with next = all ones and count = the number of its bytes, which is 1 to PAYLOAD. A frame whose length is an exact multiple of PAYLOAD takes no extra page.
- R4: A stored frame produces exactly one completion pulse. The pulse carries the frame's first page pointer and occurs in the cycle after the last byte is written, together with the last header write.
- R5: A frame that needs more than MAX_PAGES pages is dropped. Its MAX_PAGES pages are returned, and no completion is signalled.
- R6: If the free-pointer FIFO is empty when a page is needed, the frame is dropped and the pages it already took are returned. If this happens at the start of the frame, nothing is returned.
- R7: Returned pointers appear one per cycle on the return port, in the order they were taken, after the dropped frame has been drained.
- R8: The block never pops an empty free-pointer FIFO, and it pops exactly one pointer per page it uses. Pointers beyond those stay in the FIFO.
- R9: Bytes that arrive while idle without a start marker are popped and discarded. They cause no memory write and no pointer pop.
- R10: The refill request is high exactly when the free-pointer FIFO reports not full.
- R11: After reset, the memory write, header write, return, completion and both pop outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Receive data FIFO not empty |
| rx_byte | input | 8 | Byte at the head of the receive data FIFO |
| rx_first | input | 1 | Head byte is the first byte of a frame |
| rx_last | input | 1 | Head byte is the last byte of a frame |
| rx_pop | output | 1 | Consume the head byte |
| fp_avail | input | 1 | Free-pointer FIFO not empty |
| fp_full | input | 1 | Free-pointer FIFO full |
| fp_head | input | PTR_W | Pointer at the head of the free-pointer FIFO |
| fp_take | output | 1 | Consume the head pointer |
| refill_req | output | 1 | Request more free pointers (get-free-page) |
| mem_we | output | 1 | Payload byte write strobe |
| mem_addr | output | PTR_W+log2(PAGE_BYTES) | Payload byte address |
| mem_wdata | output | 8 | Payload byte |
| link_we | output | 1 | Header write strobe |
| link_page | output | PTR_W | Page whose header is written |
| link_next | output | PTR_W | Next-page pointer, all ones on the last page |
| link_count | output | log2(PAYLOAD+1) | Valid payload bytes in the page |
| ret_valid | output | 1 | Return a pointer (put-free-page) |
| ret_ptr | output | PTR_W | Pointer being returned |
| done_valid | output | 1 | Frame stored; hand-off strobe |
| done_head | output | PTR_W | First page pointer of the stored frame |

## Verification
The bench sweeps every frame length from one byte up to two bytes past the page limit, under every supply of free pointers from none to more than the limit, with and without gaps in the byte stream. It targets several boundary cases:
- Frames that end exactly on a page boundary. A design that links too eagerly would take a spare page and write a wrong last count.
- The first byte beyond the page limit. An off-by-one here would either store an oversized frame or drop a legal one.
- An empty pointer FIFO at the start of a frame and again in the middle of a frame. A design that mishandles these would return pointers it never took, lose pointers it did take, or still signal completion.
- Stray unframed bytes. These must leave memory and the pointer FIFO untouched.

// File: rtl/rpw_pkg.sv
package rpw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,   // waiting for a start marker
      ST_BODY,   // storing payload bytes
      ST_LAST,   // closing header of the final page
      ST_DROP,   // draining a rejected frame
      ST_RET     // handing back the pages of a rejected frame
   } rpw_state_e;

   function automatic int unsigned rpw_clog2(input int unsigned v);
      int unsigned r = 0;
      while ((32'd1 << r) < v) r++;
      return (r == 0) ? 1 : r;
   endfunction

endpackage

// File: rtl/rpw_page_list.sv
module rpw_page_list #(
   parameter int PTR_W     = 11,
   parameter int MAX_PAGES = 7,
   localparam int PG_W     = rpw_pkg::rpw_clog2(MAX_PAGES + 1),
   localparam int IDX_W    = rpw_pkg::rpw_clog2(MAX_PAGES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [PTR_W-1:0] push_ptr,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [PG_W-1:0]  count
);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) count <= '0;
      else if (push)     count <= count + PG_W'(1);
   end

   generate
      if (MAX_PAGES == 1) begin : g_single
         logic [PTR_W-1:0] slot;
         always_ff @(posedge clk) begin
            if (push) slot <= push_ptr;
         end
         assign rd_ptr = slot;
      end else begin : g_array
         logic [PTR_W-1:0] slots [MAX_PAGES];
         always_ff @(posedge clk) begin
            if (push) slots[count[IDX_W-1:0]] <= push_ptr;
         end
         assign rd_ptr = slots[rd_idx];
      end
   endgenerate

   // R5: a frame never owns more pages than the limit
   p_page_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      count <= PG_W'(MAX_PAGES));

   // R5: no page is taken once the limit is reached
   p_no_push_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> count < PG_W'(MAX_PAGES));

endmodule

// File: rtl/rpw_fill_ctrl.sv
module rpw_fill_ctrl #(
   parameter int PTR_W      = 11,
   parameter int PAGE_BYTES = 256,
   parameter int HDR_BYTES  = 16,
   parameter int MAX_PAGES  = 7,
   localparam int PAYLOAD   = PAGE_BYTES - HDR_BYTES,
   localparam int OFF_W     = rpw_pkg::rpw_clog2(PAGE_BYTES),
   localparam int CNT_W     = rpw_pkg::rpw_clog2(PAYLOAD + 1),
   localparam int PG_W      = rpw_pkg::rpw_clog2(MAX_PAGES + 1),
   localparam int IDX_W     = rpw_pkg::rpw_clog2(MAX_PAGES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rx_valid,
   input  logic                   rx_first,
   input  logic                   rx_last,
   output logic                   rx_pop,
   input  logic                   fp_avail,
   input  logic [PTR_W-1:0]       fp_head,
   output logic                   fp_take,
   output logic                   mem_we,
   output logic [PTR_W+OFF_W-1:0] mem_addr,
   output logic                   link_we,
   output logic [PTR_W-1:0]       link_page,
   output logic [PTR_W-1:0]       link_next,
   output logic [CNT_W-1:0]       link_count,
   output logic                   ret_valid,
   output logic [PTR_W-1:0]       ret_ptr,
   output logic                   done_valid,
   output logic [PTR_W-1:0]       done_head,
   output logic                   list_clr,
   output logic                   list_push,
   input  logic [PG_W-1:0]        list_cnt,
   output logic [IDX_W-1:0]       list_idx,
   input  logic [PTR_W-1:0]       list_ptr
);
   import rpw_pkg::*;

   localparam logic [OFF_W-1:0] HDR_OFF  = OFF_W'(HDR_BYTES);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(PAYLOAD);
   localparam logic [PG_W-1:0]  LIMIT    = PG_W'(MAX_PAGES);

   rpw_state_e       st, st_n;
   logic [PTR_W-1:0] cur, cur_n, head, head_n;
   logic [CNT_W-1:0] fill, fill_n;
   logic [IDX_W-1:0] ridx, ridx_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         cur  <= '0;
         head <= '0;
         fill <= '0;
         ridx <= '0;
      end else begin
         st   <= st_n;
         cur  <= cur_n;
         head <= head_n;
         fill <= fill_n;
         ridx <= ridx_n;
      end
   end

   always_comb begin
      st_n       = st;
      cur_n      = cur;
      head_n     = head;
      fill_n     = fill;
      ridx_n     = ridx;
      rx_pop     = 1'b0;
      fp_take    = 1'b0;
      mem_we     = 1'b0;
      mem_addr   = {cur, HDR_OFF + OFF_W'(fill)};
      link_we    = 1'b0;
      link_page  = cur;
      link_next  = fp_head;
      link_count = fill;
      ret_valid  = 1'b0;
      ret_ptr    = list_ptr;
      done_valid = 1'b0;
      done_head  = head;
      list_clr   = 1'b0;
      list_push  = 1'b0;
      list_idx   = ridx;
      unique case (st)
         ST_IDLE: begin
            if (rx_valid) begin
               rx_pop = 1'b1;
               if (rx_first) begin
                  if (fp_avail) begin
                     fp_take   = 1'b1;
                     list_push = 1'b1;
                     mem_we    = 1'b1;
                     mem_addr  = {fp_head, HDR_OFF};
                     cur_n     = fp_head;
                     head_n    = fp_head;
                     fill_n    = CNT_W'(1);
                     st_n      = rx_last ? ST_LAST : ST_BODY;
                  end else if (!rx_last) begin
                     st_n = ST_DROP;
                  end
               end
            end
         end
         ST_BODY: begin
            if (rx_valid) begin
               if (fill != FULL_CNT) begin
                  rx_pop = 1'b1;
                  mem_we = 1'b1;
                  fill_n = fill + CNT_W'(1);
                  if (rx_last) st_n = ST_LAST;
               end else if (list_cnt == LIMIT || !fp_avail) begin
                  st_n = ST_DROP;
               end else begin
                  fp_take    = 1'b1;
                  list_push  = 1'b1;
                  link_we    = 1'b1;
                  link_count = FULL_CNT;
                  cur_n      = fp_head;
                  fill_n     = '0;
               end
            end
         end
         ST_LAST: begin
            link_we    = 1'b1;
            link_next  = '1;
            done_valid = 1'b1;
            list_clr   = 1'b1;
            st_n       = ST_IDLE;
         end
         ST_DROP: begin
            ridx_n = '0;
            if (rx_valid) begin
               rx_pop = 1'b1;
               if (rx_last) st_n = (list_cnt != '0) ? ST_RET : ST_IDLE;
            end
         end
         ST_RET: begin
            ret_valid = 1'b1;
            if (PG_W'(ridx) + PG_W'(1) == list_cnt) begin
               list_clr = 1'b1;
               st_n     = ST_IDLE;
            end else begin
               ridx_n = ridx + IDX_W'(1);
            end
         end
         default: st_n = ST_IDLE;
      endcase
   end

   // R1: payload never lands inside the header area
   p_payload_region_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_addr[OFF_W-1:0] >= HDR_OFF);

   // R2: a link header adds exactly one page to the frame's list
   p_link_adds_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (link_we && link_next != '1) |=> list_cnt == $past(list_cnt) + PG_W'(1));

   // R3: every header count lies in 1..PAYLOAD
   p_count_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |-> (link_count != '0 && link_count <= FULL_CNT));

   // R4: completion follows the write of the final byte
   p_done_after_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> $past(mem_we));

   // R4: completion releases the page list
   p_done_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> list_cnt == '0);

   // R7: returns stop only once every taken page is handed back
   p_returns_complete_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ret_valid) |-> list_cnt == '0);

   // R8: no pop from an empty free-pointer FIFO
   p_no_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fp_take |-> fp_avail);

endmodule

// File: rtl/rx_page_writer.sv
module rx_page_writer #(
   parameter int PTR_W      = 11,
   parameter int PAGE_BYTES = 256,
   parameter int HDR_BYTES  = 16,
   parameter int MAX_PAGES  = 7,
   localparam int PAYLOAD   = PAGE_BYTES - HDR_BYTES,
   localparam int OFF_W     = rpw_pkg::rpw_clog2(PAGE_BYTES),
   localparam int CNT_W     = rpw_pkg::rpw_clog2(PAYLOAD + 1),
   localparam int ADDR_W    = PTR_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              rx_first,
   input  logic              rx_last,
   output logic              rx_pop,
   input  logic              fp_avail,
   input  logic              fp_full,
   input  logic [PTR_W-1:0]  fp_head,
   output logic              fp_take,
   output logic              refill_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              link_we,
   output logic [PTR_W-1:0]  link_page,
   output logic [PTR_W-1:0]  link_next,
   output logic [CNT_W-1:0]  link_count,
   output logic              ret_valid,
   output logic [PTR_W-1:0]  ret_ptr,
   output logic              done_valid,
   output logic [PTR_W-1:0]  done_head
);

   localparam int PG_W  = rpw_pkg::rpw_clog2(MAX_PAGES + 1);
   localparam int IDX_W = rpw_pkg::rpw_clog2(MAX_PAGES);

   generate
      if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two");
      end
      if (HDR_BYTES < 1 || HDR_BYTES >= PAGE_BYTES) begin : g_bad_hdr
         $error("HDR_BYTES must lie in 1..PAGE_BYTES-1");
      end
      if (MAX_PAGES < 1) begin : g_bad_max
         $error("MAX_PAGES must be at least 1");
      end
      if (PTR_W < 1) begin : g_bad_ptr
         $error("PTR_W must be at least 1");
      end
   endgenerate

   logic             list_clr, list_push;
   logic [PG_W-1:0]  list_cnt;
   logic [IDX_W-1:0] list_idx;
   logic [PTR_W-1:0] list_ptr;

   assign refill_req = ~fp_full;
   assign mem_wdata  = rx_byte;

   rpw_fill_ctrl #(
      .PTR_W(PTR_W), .PAGE_BYTES(PAGE_BYTES),
      .HDR_BYTES(HDR_BYTES), .MAX_PAGES(MAX_PAGES)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .rx_valid(rx_valid), .rx_first(rx_first), .rx_last(rx_last), .rx_pop(rx_pop),
      .fp_avail(fp_avail), .fp_head(fp_head), .fp_take(fp_take),
      .mem_we(mem_we), .mem_addr(mem_addr),
      .link_we(link_we), .link_page(link_page), .link_next(link_next),
      .link_count(link_count),
      .ret_valid(ret_valid), .ret_ptr(ret_ptr),
      .done_valid(done_valid), .done_head(done_head),
      .list_clr(list_clr), .list_push(list_push), .list_cnt(list_cnt),
      .list_idx(list_idx), .list_ptr(list_ptr)
   );

   rpw_page_list #(.PTR_W(PTR_W), .MAX_PAGES(MAX_PAGES)) u_list (
      .clk(clk), .rst_n(rst_n), .clr(list_clr), .push(list_push),
      .push_ptr(fp_head), .rd_idx(list_idx), .rd_ptr(list_ptr), .count(list_cnt)
   );

   // R4: completion never coincides with a pointer return
   p_done_not_ret_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_valid && ret_valid));

   // R9: unframed input never takes a pointer
   p_take_needs_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fp_take && !link_we) |-> (rx_valid && rx_first));

endmodule

// File: tb/rx_page_writer_test.sv
module rx_page_writer_test;

   localparam int PW = 5, PB = 32, HB = 4, MP = 3, PAY = 28, CW = 5;
   localparam int NULLP = 31;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0;
   logic rx_valid = 1'b0, rx_first = 1'b0, rx_last = 1'b0;
   logic [7:0] rx_byte = '0;
   logic fp_avail = 1'b0, fp_full = 1'b0;
   logic [PW-1:0] fp_head = '0;
   logic rx_pop, fp_take, refill_req, mem_we, link_we, ret_valid, done_valid;
   logic [PW+4:0] mem_addr;
   logic [7:0] mem_wdata;
   logic [PW-1:0] link_page, link_next, ret_ptr, done_head;
   logic [CW-1:0] link_count;

   rx_page_writer #(.PTR_W(PW), .PAGE_BYTES(PB), .HDR_BYTES(HB), .MAX_PAGES(MP)) uut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .rx_first(rx_first), .rx_last(rx_last), .rx_pop(rx_pop),
      .fp_avail(fp_avail), .fp_full(fp_full), .fp_head(fp_head), .fp_take(fp_take),
      .refill_req(refill_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .link_we(link_we), .link_page(link_page),
      .link_next(link_next), .link_count(link_count), .ret_valid(ret_valid),
      .ret_ptr(ret_ptr), .done_valid(done_valid), .done_head(done_head)
   );

   int checks = 0, fails = 0, cyc = 0;
   bit gap = 1'b0, finished = 1'b0;
   logic [7:0] dq[$];
   bit sq[$], eq[$];
   logic [PW-1:0] fq[$];
   logic [PW-1:0] ret_q[$];
   logic [7:0] mem [0:1023];
   logic [PW-1:0] hnx [0:31];
   int hct [0:31];
   int wr_count = 0, done_cnt = 0;
   logic [PW-1:0] done_seen = '0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // memory / FIFO model: sample mid-cycle, drive just after the edge
   always begin
      @(negedge clk);
      if (rst_n) begin
         if (rx_pop && dq.size() > 0) begin
            void'(dq.pop_front()); void'(sq.pop_front()); void'(eq.pop_front());
         end
         if (fp_take && fq.size() > 0) void'(fq.pop_front());
         if (mem_we) begin mem[mem_addr] = mem_wdata; wr_count++; end
         if (link_we) begin hnx[link_page] = link_next; hct[link_page] = int'(link_count); end
         if (ret_valid) ret_q.push_back(ret_ptr);
         if (done_valid) begin done_cnt++; done_seen = done_head; end
      end
      @(posedge clk);
      #1;
      cyc++;
      rx_valid = (dq.size() > 0) && !(gap && (cyc % 4 == 1));
      if (dq.size() > 0) begin rx_byte = dq[0]; rx_first = sq[0]; rx_last = eq[0]; end
      fp_avail = fq.size() > 0;
      fp_head  = (fq.size() > 0) ? fq[0] : '0;
      fp_full  = fq.size() >= 4;
   end

   function automatic logic [7:0] byte_of(input int l, input int k, input int a);
      return 8'((l * 5 + k * 7 + a) & 255);
   endfunction

   task automatic settle();
      while (dq.size() > 0) @(posedge clk);
      repeat (8) @(posedge clk);
   endtask

   task automatic run_frame(input int l, input int a);
      logic [PW-1:0] pl [8];
      int n, taken, seed, bad, first_bad_act, first_bad_exp;
      bit ok;
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      for (int i = 0; i < 32; i++) begin hnx[i] = '0; hct[i] = 0; end
      wr_count = 0; done_cnt = 0; ret_q.delete(); fq.delete();
      seed = (l * 3 + a) % 31;
      for (int i = 0; i < a; i++) begin
         pl[i] = PW'((seed + 3 * i) % 31);
         fq.push_back(pl[i]);
      end
      for (int k = 0; k < l; k++) begin
         dq.push_back(byte_of(l, k, a)); sq.push_back(k == 0); eq.push_back(k == l - 1);
      end
      settle();
      n  = (l + PAY - 1) / PAY;
      ok = (n <= MP) && (a >= n);
      if (ok) begin
         check(done_cnt == 1, "R4", "completion count", done_cnt, 1);
         check(done_seen == pl[0], "R4", "completion head", int'(done_seen), int'(pl[0]));
         check(fq.size() == a - n, "R8", "pointers left", fq.size(), a - n);
         check(ret_q.size() == 0, "R7", "returns on stored frame", ret_q.size(), 0);
         bad = 0;
         for (int i = 0; i < n - 1; i++) begin
            if (hnx[pl[i]] != pl[i+1] || hct[pl[i]] != PAY) bad++;
         end
         check(bad == 0, "R2", "link headers wrong", bad, 0);
         check(hnx[pl[n-1]] == PW'(NULLP), "R3", "last next", int'(hnx[pl[n-1]]), NULLP);
         check(hct[pl[n-1]] == l - PAY * (n - 1), "R3", "last count",
               hct[pl[n-1]], l - PAY * (n - 1));
         bad = 0; first_bad_act = 0; first_bad_exp = 0;
         for (int k = 0; k < l; k++) begin
            int addr = int'(pl[k / PAY]) * PB + HB + (k % PAY);
            if (mem[addr] != byte_of(l, k, a)) begin
               if (bad == 0) begin first_bad_act = int'(mem[addr]); first_bad_exp = int'(byte_of(l, k, a)); end
               bad++;
            end
         end
         check(bad == 0, "R1", "payload byte", first_bad_act, first_bad_exp);
      end else begin
         taken = (a < MP) ? a : MP;
         check(done_cnt == 0, (n > MP) ? "R5" : "R6", "completion on drop", done_cnt, 0);
         check(ret_q.size() == taken, (n > MP) ? "R5" : "R6", "returned count",
               ret_q.size(), taken);
         bad = 0;
         for (int i = 0; i < taken && i < ret_q.size(); i++) if (ret_q[i] != pl[i]) bad++;
         check(bad == 0, "R7", "return order mismatches", bad, 0);
         check(fq.size() == a - taken, "R8", "pointers left", fq.size(), a - taken);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R11: quiet outputs after reset
      check(!mem_we && !link_we && !ret_valid && !done_valid && !rx_pop && !fp_take,
            "R11", "idle outputs", {mem_we, link_we, ret_valid, done_valid, rx_pop, fp_take}, 0);
      check(refill_req == 1'b1, "R10", "refill with empty FIFO", int'(refill_req), 1);

      // R10: refill request follows the full flag
      for (int i = 0; i < 4; i++) fq.push_back(PW'(i));
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(refill_req == 1'b0, "R10", "refill with full FIFO", int'(refill_req), 0);

      // R9: unframed bytes are discarded
      fq.delete(); fq.push_back(PW'(7)); fq.push_back(PW'(9));
      wr_count = 0; done_cnt = 0;
      for (int k = 0; k < 3; k++) begin
         dq.push_back(8'(k + 1)); sq.push_back(1'b0); eq.push_back(k == 1);
      end
      settle();
      check(wr_count == 0, "R9", "writes from stray bytes", wr_count, 0);
      check(fq.size() == 2, "R9", "pointers after stray bytes", fq.size(), 2);
      check(done_cnt == 0, "R9", "completion from stray bytes", done_cnt, 0);

      // sweep lengths, pointer supply and input gaps (R1..R8)
      for (int g = 0; g < 2; g++) begin
         gap = (g == 1);
         for (int a = 0; a <= MP + 1; a++) begin
            for (int l = 1; l <= MP * PAY + 2; l++) begin
               if (!finished) run_frame(l, a);
            end
         end
      end

      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule